// File: doc/BRIEF.md
# Infrared Pulse Modulator with Gated Mode Configuration

This block turns a bit-serial transmit request into the short optical pulses used by slow and medium rate infrared links. A zero bit, the start bit included, is sent as one pulse. A one bit or an idle line sends nothing. The pulse length is counted in ticks, not as a fixed fraction of the bit. Each tick is the primary clock divided down to 8 MHz (40 MHz input) or 16 MHz (48 MHz input), then divided again by the baud divisor plus one. Because of this, a pulse can be made shorter than the nominal three-sixteenths of a bit time, which saves transceiver power.

The block also owns the gate for the physical-layer settings. While the phy enable is low, software sets up a next-control word, the mode bits and the clock select. All of these take effect together on the next rising edge of the phy enable. A current-control read-back shows what was applied. A read-only error flag reports a request for more than one line mode. Transmit and receive enable status and the polarity of both lines are also handled here.

Top module: `irpwm_top`

## Requirements
- R1: `cur_ctl` reads back the value that `nxt_ctl` had in the cycle where `phy_en` is first sampled high after being low. It appears one cycle later and holds while `phy_en` stays high. Field layout: [15:10] baud divisor, [9:5] pulse width, [4:0] preamble.
- R2: The mode requests (`req_sir`, `req_mir`, `req_fir`, `req_crc16`) and `clk48_sel` are applied on that same rising edge. The on-status outputs show them one cycle later. The on-status outputs return to 0 one cycle after `phy_en` is sampled low.
- R3: If more than one of `req_sir`, `req_mir`, `req_fir` is set at the rising edge, `cfg_err` becomes 1 and no mode or CRC status turns on. The next rising edge with at most one line mode set clears `cfg_err`.
- R4: `txen_st` equals `tx_en`. `rxen_st` equals `rx_en AND (NOT tx_en OR loop_en)`.
- R5: A pulse lasts exactly P × (baud+1) × (width+1) primary clock cycles. P is 5 when the applied clock select is 0 (40 MHz) and 3 when it is 1 (48 MHz).
- R6: A strobe with `tx_bit`=0 starts a pulse in the cycle after the strobe is sampled. A strobe with `tx_bit`=1 produces no pulse.
- R7: A zero-bit strobe that arrives while a pulse is active is ignored and does not change the pulse length.
- R8: No pulse is sent unless `phy_en`, `tx_en` and one of the applied SIR or MIR modes are all active. FIR mode, a configuration error, or `tx_en`=0 keeps `ir_tx` inactive.
- R9: `ir_tx` is `tx_inv` when idle and `NOT tx_inv` during a pulse.
- R10: While `phy_en` is low, `ir_tx` equals `tx_inv` in the same cycle, and any pulse in progress is abandoned.
- R11: `rx_data` is `ir_rx XOR rx_inv` while `rxen_st` is 1, and 0 otherwise.
- R12: After reset, `cur_ctl` is 0, all on-status outputs and `cfg_err` are 0, and `ir_tx` equals `tx_inv`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Primary clock (40 or 48 MHz) |
| rst_n | input | 1 | Active-low synchronous reset |
| phy_en | input | 1 | Phy enable; its rising edge applies the configuration |
| nxt_ctl | input | 16 | Next-control word: baud, pulse width, preamble |
| req_sir | input | 1 | Request slow-rate mode |
| req_mir | input | 1 | Request medium-rate mode |
| req_fir | input | 1 | Request fast-rate mode |
| req_crc16 | input | 1 | Request 16-bit CRC |
| clk48_sel | input | 1 | 1 when the primary clock is 48 MHz, 0 for 40 MHz |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| loop_en | input | 1 | Loopback enable |
| tx_inv | input | 1 | Invert the transmit line |
| rx_inv | input | 1 | Invert the receive line |
| tx_stb | input | 1 | Bit strobe from the serializer |
| tx_bit | input | 1 | Bit value for the strobe |
| ir_rx | input | 1 | Raw receive line |
| ir_tx | output | 1 | Transmit line to the LED driver |
| rx_data | output | 1 | Receive line after polarity and enable |
| cur_ctl | output | 16 | Applied control word read-back |
| sir_on | output | 1 | Slow-rate mode active |
| mir_on | output | 1 | Medium-rate mode active |
| fir_on | output | 1 | Fast-rate mode active |
| crc16_on | output | 1 | 16-bit CRC active |
| cfg_err | output | 1 | Conflicting line modes were requested |
| txen_st | output | 1 | Transmit enable status |
| rxen_st | output | 1 | Receive enable status |

## Verification
The gate's outputs change one cycle after the `phy_en` rise is sampled. The bench therefore raises `phy_en` on a falling edge and reads the status and read-back at the next falling edge. Pulses start one cycle after the strobe is sampled. The bench counts, one per falling edge, the cycles on which `ir_tx` is active and compares the count with P × (baud+1) × (width+1), computed by a bench function. The enable status, receive path and phy-low masking are combinational, so they are read a few time units after the inputs change, well before the next edge.

// File: rtl/irpwm_pkg.sv
package irpwm_pkg;
   parameter int BAUD_W = 6;
   parameter int WID_W  = 5;
   parameter int PAM_W  = 5;
   localparam int CTL_W = BAUD_W + WID_W + PAM_W;

   // field order is decoded by the pulse generator: divisor on top
   typedef struct packed {
      logic [BAUD_W-1:0] baud;
      logic [WID_W-1:0]  width;
      logic [PAM_W-1:0]  pream;
   } phy_word_t;

   typedef struct packed {
      logic sir;
      logic mir;
      logic fir;
      logic crc16;
   } mode_t;
endpackage

// File: rtl/irpwm_cfg_gate.sv
module irpwm_cfg_gate
   import irpwm_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      phy_en,
   input  phy_word_t nxt_word,
   input  mode_t     nxt_mode,
   input  logic      nxt_clk48,
   output phy_word_t cur_word,
   output mode_t     mode_on,
   output logic      clk48_on,
   output logic      cfg_err
);
   logic phy_q;
   logic rise;
   logic multi;

   assign rise  = phy_en & ~phy_q;
   assign multi = (2'(nxt_mode.sir) + 2'(nxt_mode.mir) + 2'(nxt_mode.fir)) > 2'd1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phy_q    <= 1'b0;
         cur_word <= '0;
         mode_on  <= '0;
         clk48_on <= 1'b0;
         cfg_err  <= 1'b0;
      end else begin
         phy_q <= phy_en;
         if (rise) begin
            cur_word <= nxt_word;
            clk48_on <= nxt_clk48;
            cfg_err  <= multi;
            mode_on  <= multi ? '0 : nxt_mode;
         end else if (!phy_en) begin
            mode_on <= '0;
         end
      end
   end

   // R1
   cur_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(phy_en && !phy_q) |=> $stable(cur_word));
   // R3
   err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> (mode_on == '0));
   // R2
   one_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mode_on.sir, mode_on.mir, mode_on.fir}));
   // R2
   down_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !phy_en |=> (mode_on == '0));
endmodule

// File: rtl/irpwm_pulse_gen.sv
module irpwm_pulse_gen #(
   parameter int BAUD_W   = 6,
   parameter int WID_W    = 5,
   parameter int PRE_SLOW = 5,
   parameter int PRE_FAST = 3,
   parameter bit DUAL_CLK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              start,
   input  logic              fast,
   input  logic [BAUD_W-1:0] baud,
   input  logic [WID_W-1:0]  width,
   output logic              busy
);
   localparam int DIV_MAX = (PRE_SLOW > PRE_FAST) ? PRE_SLOW : PRE_FAST;
   localparam int CNT_W   = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;

   initial begin : prm_chk
      assert (PRE_SLOW >= 2 && PRE_FAST >= 2 && BAUD_W >= 1 && WID_W >= 1)
         else $error("irpwm_pulse_gen: bad parameters");
   end

   logic [CNT_W-1:0]  div_last;
   logic [CNT_W-1:0]  pre_cnt;
   logic [BAUD_W-1:0] bcnt;
   logic [WID_W-1:0]  wcnt;

   generate
      if (DUAL_CLK) begin : g_dual
         assign div_last = fast ? CNT_W'(PRE_FAST - 1) : CNT_W'(PRE_SLOW - 1);
      end else begin : g_single
         logic unused_fast;
         assign unused_fast = fast;
         assign div_last = CNT_W'(PRE_SLOW - 1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         pre_cnt <= '0;
         bcnt    <= '0;
         wcnt    <= '0;
      end else if (!run) begin
         busy <= 1'b0;
      end else if (!busy) begin
         if (start) begin
            busy    <= 1'b1;
            pre_cnt <= '0;
            bcnt    <= '0;
            wcnt    <= '0;
         end
      end else if (pre_cnt == div_last) begin
         pre_cnt <= '0;
         if (bcnt == baud) begin
            bcnt <= '0;
            if (wcnt == width) busy <= 1'b0;
            else               wcnt <= wcnt + 1'b1;
         end else begin
            bcnt <= bcnt + 1'b1;
         end
      end else begin
         pre_cnt <= pre_cnt + 1'b1;
      end
   end

   // R10
   abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !busy);
   // R5
   range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (wcnt <= width && bcnt <= baud));
   // R6
   launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && run && start) |=> (busy && wcnt == '0));
endmodule

// File: rtl/irpwm_top.sv
module irpwm_top
   import irpwm_pkg::*;
#(
   parameter int PRE_SLOW = 5,
   parameter int PRE_FAST = 3,
   parameter bit DUAL_CLK = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             phy_en,
   input  logic [CTL_W-1:0] nxt_ctl,
   input  logic             req_sir,
   input  logic             req_mir,
   input  logic             req_fir,
   input  logic             req_crc16,
   input  logic             clk48_sel,
   input  logic             tx_en,
   input  logic             rx_en,
   input  logic             loop_en,
   input  logic             tx_inv,
   input  logic             rx_inv,
   input  logic             tx_stb,
   input  logic             tx_bit,
   input  logic             ir_rx,
   output logic             ir_tx,
   output logic             rx_data,
   output logic [CTL_W-1:0] cur_ctl,
   output logic             sir_on,
   output logic             mir_on,
   output logic             fir_on,
   output logic             crc16_on,
   output logic             cfg_err,
   output logic             txen_st,
   output logic             rxen_st
);
   phy_word_t cur_word;
   mode_t     req_mode;
   mode_t     mode_on;
   logic      clk48_on;
   logic      run;
   logic      busy;

   assign req_mode = '{sir: req_sir, mir: req_mir, fir: req_fir, crc16: req_crc16};

   irpwm_cfg_gate u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .phy_en    (phy_en),
      .nxt_word  (phy_word_t'(nxt_ctl)),
      .nxt_mode  (req_mode),
      .nxt_clk48 (clk48_sel),
      .cur_word  (cur_word),
      .mode_on   (mode_on),
      .clk48_on  (clk48_on),
      .cfg_err   (cfg_err)
   );

   assign run = phy_en & tx_en & (mode_on.sir | mode_on.mir);

   irpwm_pulse_gen #(
      .BAUD_W   (BAUD_W),
      .WID_W    (WID_W),
      .PRE_SLOW (PRE_SLOW),
      .PRE_FAST (PRE_FAST),
      .DUAL_CLK (DUAL_CLK)
   ) u_pulse (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .start (tx_stb & ~tx_bit),
      .fast  (clk48_on),
      .baud  (cur_word.baud),
      .width (cur_word.width),
      .busy  (busy)
   );

   assign ir_tx    = (busy & phy_en) ^ tx_inv;
   assign txen_st  = tx_en;
   assign rxen_st  = rx_en & (~tx_en | loop_en);
   assign rx_data  = rxen_st & (ir_rx ^ rx_inv);
   assign cur_ctl  = cur_word;
   assign sir_on   = mode_on.sir;
   assign mir_on   = mode_on.mir;
   assign fir_on   = mode_on.fir;
   assign crc16_on = mode_on.crc16;

   // R8
   fir_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fir_on || cfg_err) |-> (ir_tx == tx_inv));
   // R10
   down_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !phy_en |-> (ir_tx == tx_inv));
endmodule

// File: tb/irpwm_top_test.sv
module irpwm_top_test;
   localparam int CLK_NS = 10;

   logic        clk = 1'b0;
   logic        rst_n, phy_en, req_sir, req_mir, req_fir, req_crc16, clk48_sel;
   logic        tx_en, rx_en, loop_en, tx_inv, rx_inv, tx_stb, tx_bit, ir_rx;
   logic [15:0] nxt_ctl;
   logic        ir_tx, rx_data, sir_on, mir_on, fir_on, crc16_on, cfg_err, txen_st, rxen_st;
   logic [15:0] cur_ctl;
   int          total = 0;
   int          bad = 0;

   always #(CLK_NS/2) clk = ~clk;

   irpwm_top uut (
      .clk(clk), .rst_n(rst_n), .phy_en(phy_en), .nxt_ctl(nxt_ctl),
      .req_sir(req_sir), .req_mir(req_mir), .req_fir(req_fir), .req_crc16(req_crc16),
      .clk48_sel(clk48_sel), .tx_en(tx_en), .rx_en(rx_en), .loop_en(loop_en),
      .tx_inv(tx_inv), .rx_inv(rx_inv), .tx_stb(tx_stb), .tx_bit(tx_bit), .ir_rx(ir_rx),
      .ir_tx(ir_tx), .rx_data(rx_data), .cur_ctl(cur_ctl), .sir_on(sir_on), .mir_on(mir_on),
      .fir_on(fir_on), .crc16_on(crc16_on), .cfg_err(cfg_err), .txen_st(txen_st), .rxen_st(rxen_st)
   );

   function automatic int exp_len(int b, int w, bit c48);
      return (c48 ? 3 : 5) * (b + 1) * (w + 1);
   endfunction

   function automatic logic [15:0] pack_word(int b, int w, int p);
      return {6'(b), 5'(w), 5'(p)};
   endfunction

   task automatic check(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   task automatic apply_cfg(logic [15:0] w, logic [3:0] m, logic c48);
      @(negedge clk) phy_en = 1'b0;
      @(negedge clk);
      nxt_ctl = w;
      {req_sir, req_mir, req_fir, req_crc16} = m;
      clk48_sel = c48;
      @(negedge clk) phy_en = 1'b1;
      @(negedge clk);
   endtask

   task automatic measure(bit inject, output int len);
      tx_stb = 1'b1;
      tx_bit = 1'b0;
      @(negedge clk);
      tx_stb = 1'b0;
      len = 0;
      while (ir_tx != tx_inv && len < 20000) begin
         len++;
         if (inject && len == 1) begin
            tx_stb = 1'b1;
            tx_bit = 1'b0;
         end else begin
            tx_stb = 1'b0;
         end
         @(negedge clk);
      end
      tx_stb = 1'b0;
   endtask

   task automatic quiet(logic bitv, output int act);
      tx_stb = 1'b1;
      tx_bit = bitv;
      @(negedge clk);
      tx_stb = 1'b0;
      act = 0;
      repeat (20) begin
         if (ir_tx != tx_inv) act++;
         @(negedge clk);
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog act=1 exp=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      int len;
      int act;
      void'($urandom(32'd4242));
      rst_n = 1'b0; phy_en = 1'b0; nxt_ctl = '0;
      {req_sir, req_mir, req_fir, req_crc16} = 4'b0;
      clk48_sel = 1'b0; tx_en = 1'b0; rx_en = 1'b0; loop_en = 1'b0;
      tx_inv = 1'b0; rx_inv = 1'b0; tx_stb = 1'b0; tx_bit = 1'b1; ir_rx = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R12 reset state
      check("R12 cur_ctl", int'(cur_ctl), 0);
      check("R12 status", int'({sir_on, mir_on, fir_on, crc16_on, cfg_err}), 0);
      check("R12 ir_tx", int'(ir_tx), 0);

      // R4 enable status truth table
      for (int k = 0; k < 8; k++) begin
         {tx_en, rx_en, loop_en} = 3'(k);
         #1;
         check("R4 txen_st", int'(txen_st), int'(tx_en));
         check("R4 rxen_st", int'(rxen_st), int'(rx_en & (~tx_en | loop_en)));
      end

      // R11 receive polarity and gating
      tx_en = 1'b0; rx_en = 1'b1; loop_en = 1'b0; ir_rx = 1'b1; rx_inv = 1'b0; #1;
      check("R11 rx plain", int'(rx_data), 1);
      rx_inv = 1'b1; #1;
      check("R11 rx inverted", int'(rx_data), 0);
      tx_en = 1'b1; ir_rx = 1'b0; #1;
      check("R11 rx gated", int'(rx_data), 0);
      rx_inv = 1'b0; rx_en = 1'b0;

      // R1 R2 capture at rise: 2400 baud, nominal width at 40 MHz
      apply_cfg(pack_word(47, 12, 0), 4'b1000, 1'b0);
      check("R1 capture", int'(cur_ctl), int'(pack_word(47, 12, 0)));
      check("R2 sir_on", int'({sir_on, mir_on, fir_on, crc16_on}), 8);
      nxt_ctl = 16'h1234;
      {req_sir, req_mir} = 2'b01;
      repeat (3) @(negedge clk);
      check("R1 hold", int'(cur_ctl), int'(pack_word(47, 12, 0)));
      check("R2 hold", int'({sir_on, mir_on}), 2);

      // R5 directed long pulse
      measure(1'b0, len);
      check("R5 2400 nominal", len, exp_len(47, 12, 1'b0));

      // R6 one bit gives nothing
      quiet(1'b1, act);
      check("R6 one bit", act, 0);

      // R7 strobe during pulse ignored
      apply_cfg(pack_word(3, 4, 0), 4'b1000, 1'b0);
      measure(1'b1, len);
      check("R7 retrigger", len, exp_len(3, 4, 1'b0));
      repeat (3) @(negedge clk);
      check("R7 idle after", int'(ir_tx), int'(tx_inv));

      // R5 medium rate at 48 MHz
      apply_cfg(pack_word(0, 10, 1), 4'b0101, 1'b1);
      check("R2 mir crc", int'({sir_on, mir_on, fir_on, crc16_on}), 5);
      measure(1'b0, len);
      check("R5 mir 48", len, exp_len(0, 10, 1'b1));

      // R10 phy low aborts, inverted polarity
      tx_inv = 1'b1;
      apply_cfg(pack_word(5, 20, 0), 4'b1000, 1'b0);
      check("R9 idle inverted", int'(ir_tx), 1);
      tx_stb = 1'b1; tx_bit = 1'b0;
      @(negedge clk) tx_stb = 1'b0;
      check("R9 active inverted", int'(ir_tx), 0);
      repeat (4) @(negedge clk);
      phy_en = 1'b0; #1;
      check("R10 immediate", int'(ir_tx), 1);
      @(negedge clk);
      check("R2 cleared", int'({sir_on, mir_on, fir_on, crc16_on}), 0);
      phy_en = 1'b1;
      repeat (2) @(negedge clk);
      check("R10 abandoned", int'(ir_tx), 1);
      tx_inv = 1'b0;

      // R3 conflicting modes
      apply_cfg(pack_word(0, 3, 0), 4'b1101, 1'b0);
      check("R3 err", int'(cfg_err), 1);
      check("R3 nothing on", int'({sir_on, mir_on, fir_on, crc16_on}), 0);
      quiet(1'b0, act);
      check("R8 err silent", act, 0);

      // R8 fir silent
      apply_cfg(pack_word(0, 0, 15), 4'b0010, 1'b0);
      check("R3 err cleared", int'(cfg_err), 0);
      check("R2 fir_on", int'(fir_on), 1);
      quiet(1'b0, act);
      check("R8 fir silent", act, 0);

      // R8 tx disabled
      apply_cfg(pack_word(1, 2, 0), 4'b1000, 1'b0);
      tx_en = 1'b0;
      quiet(1'b0, act);
      check("R8 tx off", act, 0);
      tx_en = 1'b1;

      // R5 R9 random configurations
      for (int i = 0; i < 12; i++) begin
         int  b;
         int  w;
         bit  c48;
         bit  mir;
         b   = int'($urandom_range(0, 11));
         w   = int'($urandom_range(0, 24));
         c48 = 1'($urandom_range(0, 1));
         mir = 1'($urandom_range(0, 1));
         tx_inv = 1'($urandom_range(0, 1));
         apply_cfg(pack_word(b, w, 0), mir ? 4'b0100 : 4'b1000, c48);
         check("R9 idle level", int'(ir_tx), int'(tx_inv));
         measure(1'b0, len);
         check("R5 random", len, exp_len(b, w, c48));
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule